// File: doc/BRIEF.md
# Two-Channel Double-Buffered Converter Input Front End

This block is the digital front end of a two-channel converter. Each channel holds a code in two stages. A staging register takes new data when a write strobe rises. A held register then drives the converter once an update strobe rises. All strobes are ordinary synchronous inputs, sampled on one fast system clock. An edge counts when a strobe is seen low in one cycle and high in the next.

The block has two modes. In dual mode the channels are fully independent, and each has its own data port, write strobe and update strobe. In interleaved mode only port 1 and its write strobe carry data. The level on the channel-2 write pin chooses the channel that receives each word. The channel-1 update strobe passes through a divide-by-two, so both held registers load together on every second update edge. The channel-2 update pin becomes a sync level that mutes updates and restarts the divide-by-two phase.

The block never stalls and has no back-pressure. Every sampled strobe edge is acted on in the cycle it is seen. Each held-register load produces a one-cycle load pulse for that channel.

Top module: `dac_dual_front`

## Requirements
- R1: The mode pin is captured only while `rst` is high (1 = dual, 0 = interleaved). A change of the mode pin outside reset has no effect on behaviour.
- R2: In dual mode, a rising edge on `wr1_i` or `wr2_i` stores that channel's port data in its staging register. A write on its own never changes `dacN_code_o` and never pulses `dacN_load_o`.
- R3: A rising edge on an update strobe is acted on at the first clock edge that samples the strobe high. At that edge the held register takes the staging value, and the channel's load pulse is high for exactly the following cycle.
- R4: In dual mode, the strobes of one channel never change the codes or load pulses of the other channel.
- R5: If write and update edges for a channel are seen in the same cycle, the held register takes the older staging value and the staging register takes the new data. A following update then moves the new data.
- R6: In interleaved mode, a rising edge on `wr1_i` stores `port1_data_i` in channel 1 when `wr2_i` is 1 and in channel 2 when `wr2_i` is 0. `port2_data_i` is ignored.
- R7: In interleaved mode, while `upd2_i` is high, rising edges on `upd1_i` load nothing.
- R8: In interleaved mode, the first `upd1_i` edge after `upd2_i` falls, or after reset, loads both channels in the same cycle. After that, only every second edge loads, and both load pulses always occur together.
- R9: Synchronous `rst` clears both staging registers, both codes and both load pulses to zero, and rearms the divide-by-two phase.
- R10: Codes are straight binary with bit 9 as MSB. A written code, including 10'h3FF and 10'h000, appears unchanged on the output.
- R11: A strobe held high for several cycles acts only once, on its first high sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; also captures the mode |
| mode_dual_i | input | 1 | 1 = dual mode, 0 = interleaved mode |
| port1_data_i | input | 10 | Channel 1 data, or the shared data in interleaved mode |
| wr1_i | input | 1 | Channel 1 write strobe, or the shared write strobe |
| upd1_i | input | 1 | Channel 1 update strobe, or the shared update strobe |
| port2_data_i | input | 10 | Channel 2 data (dual mode only) |
| wr2_i | input | 1 | Channel 2 write strobe, or the channel select level |
| upd2_i | input | 1 | Channel 2 update strobe, or the sync level |
| dac1_code_o | output | 10 | Held code for channel 1 |
| dac2_code_o | output | 10 | Held code for channel 2 |
| dac1_load_o | output | 1 | One-cycle pulse when channel 1 loads |
| dac2_load_o | output | 1 | One-cycle pulse when channel 2 loads |

## Verification
The bench first runs directed cases: full-scale and zero codes, a write strobe held high while its data changes, and write and update edges in the same cycle. These separate a one-stage path from a two-stage path and expose any update that reads the new staging value. It then runs long random strobe sequences in both modes. In dual mode they show any channel crosstalk. In interleaved mode, random select levels and sparse sync pulses test the steering and the every-second-edge phase after each sync release. A mode change without reset is also applied and must not change behaviour.

// File: rtl/dac_fe_pkg.sv
package dac_fe_pkg;
  typedef enum logic {
    MODE_SHARED = 1'b0,
    MODE_SPLIT  = 1'b1
  } fe_mode_e;

  localparam int unsigned NUM_CH     = 2;
  localparam int unsigned NUM_STROBE = 2 * NUM_CH;
endpackage

// File: rtl/dac_fe_edge.sv
module dac_fe_edge #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] prev_q;

  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk) prev_q[g] <= lvl_i[g];
    assign rise_o[g] = lvl_i[g] & ~prev_q[g];
  end
endmodule

// File: rtl/dac_fe_pace.sv
module dac_fe_pace (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic sync_i,
  input  logic edge_i,
  output logic load_o
);
  logic armed_q;

  always_ff @(posedge clk) begin
    if (rst || !en_i)  armed_q <= 1'b1;
    else if (sync_i)   armed_q <= 1'b1;
    else if (edge_i)   armed_q <= ~armed_q;
  end

  assign load_o = en_i & ~sync_i & edge_i & armed_q;
endmodule

// File: rtl/dac_fe_chan.sv
module dac_fe_chan #(
  parameter int unsigned W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cap_i,
  input  logic [W-1:0] cap_data_i,
  input  logic         xfer_i,
  output logic [W-1:0] code_o,
  output logic         load_o
);
  logic [W-1:0] stage_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= '0;
      code_o  <= '0;
      load_o  <= 1'b0;
    end else begin
      load_o <= xfer_i;
      if (xfer_i) code_o  <= stage_q;
      if (cap_i)  stage_q <= cap_data_i;
    end
  end

  AST_HOLD_CODE: assert property (@(posedge clk) disable iff (rst)
    !xfer_i |=> $stable(code_o)); // R2
endmodule

// File: rtl/dac_dual_front.sv
module dac_dual_front
  import dac_fe_pkg::*;
#(
  parameter int unsigned DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_dual_i,
  input  logic [DATA_W-1:0] port1_data_i,
  input  logic              wr1_i,
  input  logic              upd1_i,
  input  logic [DATA_W-1:0] port2_data_i,
  input  logic              wr2_i,
  input  logic              upd2_i,
  output logic [DATA_W-1:0] dac1_code_o,
  output logic [DATA_W-1:0] dac2_code_o,
  output logic              dac1_load_o,
  output logic              dac2_load_o
);
  localparam int unsigned IW1 = 0;
  localparam int unsigned IU1 = 1;
  localparam int unsigned IW2 = 2;
  localparam int unsigned IU2 = 3;

  fe_mode_e                mode_q;
  logic [NUM_STROBE-1:0]   rise;
  logic                    pair_load;
  logic                    split;
  logic [NUM_CH-1:0]       cap;
  logic [NUM_CH-1:0]       xfer;
  logic [DATA_W-1:0]       cap_data [NUM_CH];
  logic [DATA_W-1:0]       code     [NUM_CH];
  logic [NUM_CH-1:0]       load;

  always_ff @(posedge clk) begin
    if (rst) mode_q <= fe_mode_e'(mode_dual_i);
  end

  assign split = (mode_q == MODE_SPLIT);

  dac_fe_edge #(.N(NUM_STROBE)) u_edge (
    .clk    (clk),
    .lvl_i  ({upd2_i, wr2_i, upd1_i, wr1_i}),
    .rise_o (rise)
  );

  dac_fe_pace u_pace (
    .clk    (clk),
    .rst    (rst),
    .en_i   (~split),
    .sync_i (upd2_i),
    .edge_i (rise[IU1]),
    .load_o (pair_load)
  );

  always_comb begin
    if (split) begin
      cap[0]      = rise[IW1];
      cap[1]      = rise[IW2];
      xfer[0]     = rise[IU1];
      xfer[1]     = rise[IU2];
      cap_data[0] = port1_data_i;
      cap_data[1] = port2_data_i;
    end else begin
      cap[0]      = rise[IW1] & wr2_i;
      cap[1]      = rise[IW1] & ~wr2_i;
      xfer[0]     = pair_load;
      xfer[1]     = pair_load;
      cap_data[0] = port1_data_i;
      cap_data[1] = port1_data_i;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    dac_fe_chan #(.W(DATA_W)) u_chan (
      .clk        (clk),
      .rst        (rst),
      .cap_i      (cap[c]),
      .cap_data_i (cap_data[c]),
      .xfer_i     (xfer[c]),
      .code_o     (code[c]),
      .load_o     (load[c])
    );
  end

  assign dac1_code_o = code[0];
  assign dac2_code_o = code[1];
  assign dac1_load_o = load[0];
  assign dac2_load_o = load[1];

  AST_LOAD_SRC1: assert property (@(posedge clk) disable iff (rst)
    dac1_load_o |-> $past(upd1_i)); // R3
  AST_LOAD_SRC2: assert property (@(posedge clk) disable iff (rst)
    (split && dac2_load_o) |-> $past(upd2_i)); // R4
  AST_PAIRED_LOAD: assert property (@(posedge clk) disable iff (rst)
    !split |-> (dac1_load_o == dac2_load_o)); // R8
  AST_SYNC_MUTE: assert property (@(posedge clk) disable iff (rst)
    (!split && upd2_i) |=> (!dac1_load_o && !dac2_load_o)); // R7
endmodule

// File: tb/dac_dual_front_tb.sv
module dac_dual_front_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mode_dual = 1'b1;
  logic [9:0] p1 = '0, p2 = '0;
  logic       w1 = 1'b0, u1 = 1'b0, w2 = 1'b0, u2 = 1'b0;
  logic [9:0] d1, d2;
  logic       l1, l2;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  bit pw1, pu1, pw2, pu2;
  logic [9:0] mi1, mi2, md1, md2;
  bit ml1, ml2, mdual, marm;

  always #5 clk = ~clk;

  dac_dual_front u_dut (
    .clk(clk), .rst(rst), .mode_dual_i(mode_dual),
    .port1_data_i(p1), .wr1_i(w1), .upd1_i(u1),
    .port2_data_i(p2), .wr2_i(w2), .upd2_i(u2),
    .dac1_code_o(d1), .dac2_code_o(d2),
    .dac1_load_o(l1), .dac2_load_o(l2)
  );

  function automatic bit rise_of(input bit cur, input bit prev);
    return cur && !prev;
  endfunction

  task automatic tick(input string tag);
    bit ew1, eu1, ew2, eu2, n1, n2;
    ew1 = rise_of(w1, pw1); eu1 = rise_of(u1, pu1);
    ew2 = rise_of(w2, pw2); eu2 = rise_of(u2, pu2);
    n1 = 0; n2 = 0;
    if (rst) begin
      mi1 = 0; mi2 = 0; md1 = 0; md2 = 0;
      mdual = mode_dual; marm = 1;
    end else if (mdual) begin
      if (eu1) begin md1 = mi1; n1 = 1; end
      if (eu2) begin md2 = mi2; n2 = 1; end
      if (ew1) mi1 = p1;
      if (ew2) mi2 = p2;
    end else begin
      if (u2) marm = 1;
      else if (eu1) begin
        if (marm) begin md1 = mi1; md2 = mi2; n1 = 1; n2 = 1; marm = 0; end
        else marm = 1;
      end
      if (ew1) begin
        if (w2) mi1 = p1; else mi2 = p1;
      end
    end
    ml1 = n1; ml2 = n2;
    pw1 = w1; pu1 = u1; pw2 = w2; pu2 = u2;
    @(posedge clk);
    #2;
    checks++;
    if (d1 !== md1 || d2 !== md2 || l1 !== ml1 || l2 !== ml2) begin
      fails++;
      $display("FAIL %s: got c1=%h c2=%h l1=%b l2=%b expected c1=%h c2=%h l1=%b l2=%b",
               tag, d1, d2, l1, l2, md1, md2, ml1, ml2);
    end
  endtask

  task automatic drive(input bit a_w1, input bit a_u1, input bit a_w2, input bit a_u2,
                       input logic [9:0] a_p1, input logic [9:0] a_p2, input string tag);
    w1 = a_w1; u1 = a_u1; w2 = a_w2; u2 = a_u2; p1 = a_p1; p2 = a_p2;
    tick(tag);
  endtask

  task automatic do_reset(input bit m, input string tag);
    rst = 1; mode_dual = m;
    w1 = 0; u1 = 0; w2 = 0; u2 = 0;
    for (int i = 0; i < 3; i++) tick(tag);
    rst = 0;
  endtask

  task automatic random_run(input int n, input bit flip_mode, input string tag);
    for (int i = 0; i < n; i++) begin
      if (flip_mode && (i % 97 == 0)) mode_dual = ~mode_dual;
      w1 = ($urandom % 3) == 0; u1 = ($urandom % 3) == 0;
      w2 = ($urandom % 3) == 0;
      u2 = mdual ? (($urandom % 3) == 0) : (($urandom % 23) == 0);
      p1 = 10'($urandom); p2 = 10'($urandom);
      tick(tag);
    end
  endtask

  initial begin
    #(10 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_2024));
    #1;
    do_reset(1'b1, "R9_reset");
    drive(0, 0, 0, 0, 0, 0, "R9_idle");

    // R10 full scale and zero, R2 write alone leaves output
    drive(1, 0, 1, 0, 10'h3FF, 10'h000, "R2_write");
    drive(0, 0, 0, 0, 10'h155, 10'h2AA, "R2_write");
    drive(0, 1, 0, 1, 10'h155, 10'h2AA, "R10_fullscale");
    drive(0, 0, 0, 0, 0, 0, "R3_pulse_end");
    // R11 held-high write strobe acts once
    drive(1, 0, 0, 0, 10'h123, 0, "R11_hold");
    drive(1, 0, 0, 0, 10'h321, 0, "R11_hold");
    drive(1, 1, 0, 0, 10'h0F0, 0, "R11_hold");
    drive(1, 1, 0, 0, 10'h00F, 0, "R11_hold");
    drive(0, 0, 0, 0, 0, 0, "R11_hold");
    // R5 same-cycle write and update
    drive(1, 1, 0, 0, 10'h2C3, 0, "R5_same");
    drive(0, 0, 0, 0, 0, 0, "R5_same");
    drive(0, 1, 0, 0, 0, 0, "R5_next");
    // R4 channel 2 alone
    drive(0, 0, 1, 0, 0, 10'h1E1, "R4_indep");
    drive(0, 0, 0, 1, 0, 0, "R4_indep");
    drive(0, 0, 0, 0, 0, 0, "R4_indep");

    random_run(2000, 1'b0, "R2 R3 R4 dual");
    // R1 mode pin toggles without reset: no effect
    random_run(600, 1'b1, "R1_mode_hold");

    do_reset(1'b0, "R9_reset_shared");
    // R6 steering, port2 ignored
    drive(1, 0, 1, 0, 10'h3AB, 10'h111, "R6_steer");
    drive(0, 0, 0, 0, 0, 0, "R6_steer");
    drive(1, 0, 0, 0, 10'h04C, 10'h222, "R6_steer");
    drive(0, 0, 0, 1, 0, 0, "R7_sync");
    drive(0, 1, 0, 1, 0, 0, "R7_mute");
    drive(0, 0, 0, 1, 0, 0, "R7_mute");
    drive(0, 1, 0, 1, 0, 0, "R7_mute");
    drive(0, 0, 0, 0, 0, 0, "R8_release");
    drive(0, 1, 0, 0, 0, 0, "R8_first");
    drive(0, 0, 0, 0, 0, 0, "R8_first");
    drive(1, 1, 1, 0, 10'h3FF, 0, "R8_skip");
    drive(0, 0, 0, 0, 0, 0, "R8_skip");
    drive(0, 1, 0, 0, 0, 0, "R8_second");
    drive(0, 0, 0, 0, 0, 0, "R8_second");

    random_run(3000, 1'b0, "R6 R7 R8 shared");
    random_run(500, 1'b1, "R1_mode_hold_shared");

    do_reset(1'b1, "R9_reset_back");
    random_run(500, 1'b0, "R3 dual_again");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule